// File: doc/BRIEF.md
# Write-Guarded Control and Status Register

This block is an 8-bit control and status register. It sits in front of a 256-location byte memory and a set of wiper-position registers, and decides whether each write aimed at them may go ahead. Software reaches the register through one byte-wide write port. It reads the register back through a combinational read port. That read value also carries two supply-monitor flags, which are brought in through a synchronizer.

The register's own persistent fields are guarded by a two-step arming sequence. First the write-enable latch is set. Then the register-enable latch is armed. Only the next write after arming may change the lock code or the reset-delay selector. Arming is then dropped automatically.

A two-bit lock code protects an upper slice of the memory address space and freezes all wiper updates. A write-protect pin overrides everything. Every rejected attempt produces a one-cycle abort pulse. A completed persistent load produces a one-cycle program-start pulse. Writes that only move the write-enable latch never produce that pulse.

Two resets exist. `pwr_rst_n` models loss of power: it clears the volatile latches and leaves the persistent fields as they were last written. `fab_init_n` puts the persistent fields at their factory values.

Top module: `guard_csr`

## Requirements
- R1: `fab_init_n` low sets the lock code and the reset-delay selector to the factory values (both 00 by default). `pwr_rst_n` low clears both enable latches, `abort_pulse` and `prog_start`, and leaves the lock code and the selector unchanged.
- R2: `csr_rdata` is {sel[1], v2 flag, v3 flag, lock[1], lock[0], arm latch, enable latch, sel[0]}, with bit 7 first.
- R3: While the arm latch is 0, writing 0x02 sets the enable latch and writing 0x00 clears it. Neither write produces `prog_start` or `abort_pulse`.
- R4: While the arm latch is 0, writing 0x06 sets the arm latch if the enable latch is 1. If the enable latch is 0, the write is rejected.
- R5: While the arm latch is 1, any write loads the lock code from data bits 4:3 and the selector from bits {7,0}. It clears the arm latch, leaves the enable latch unchanged, and pulses `prog_start` for one cycle.
- R6: While the arm latch is 0, any write other than 0x00, 0x02 or 0x06 is rejected, and the persistent fields stay unchanged.
- R7: A memory request (`req_kind`=0) is refused when its address is locked. Lock code 01 locks the top quarter of the space (C0h-FFh), 10 locks the top half (80h-FFh), 11 locks every address, and 00 locks none.
- R8: A wiper request (`req_kind`=1) is refused whenever the lock code is not 00.
- R9: While `wp_pin` is 1, every request is refused, whatever the lock code.
- R10: A memory request to a locked address clears the arm latch on the next clock edge. This also happens when `wp_pin` is 1.
- R11: `req_permit` is combinational and equals `req_valid` with no refusal cause present. `abort_pulse` is 1 for the cycle after each rejected register write or refused request, and 0 otherwise.
- R12: The monitor inputs appear in `csr_rdata` after SYNC_STAGES clock edges (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| fab_init_n | input | 1 | Factory initialise of persistent fields, active low, asynchronous |
| pwr_rst_n | input | 1 | Power-cycle reset of volatile state, active low, asynchronous |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| mon_v2 | input | 1 | Supply monitor 2 flag (asynchronous) |
| mon_v3 | input | 1 | Supply monitor 3 flag (asynchronous) |
| wp_pin | input | 1 | Write-protect pin, active high |
| req_valid | input | 1 | Write request to memory or wiper |
| req_kind | input | 1 | 0 = memory, 1 = wiper |
| req_addr | input | ADDR_W | Memory byte address of the request |
| req_permit | output | 1 | Request may proceed |
| abort_pulse | output | 1 | One-cycle pulse after a rejected write |
| prog_start | output | 1 | One-cycle pulse when a persistent load happens |

## Verification
The assertions assume that both resets are asserted from time zero. They also assume that `req_kind` and `req_addr` are stable while `req_valid` is high. The bench changes its inputs only on falling edges and holds them for a full cycle. It asserts `fab_init_n` and `pwr_rst_n` together at start-up, and later pulses each one alone. The monitor flags are only moved in a directed phase, so that the random phase can predict the read value exactly.

// File: rtl/guard_csr_pkg.sv
package guard_csr_pkg;
   typedef enum logic [1:0] {
      LK_NONE = 2'b00,
      LK_QTR  = 2'b01,
      LK_HALF = 2'b10,
      LK_ALL  = 2'b11
   } lock_e;

   localparam logic [7:0] CMD_EN_CLR = 8'h00;
   localparam logic [7:0] CMD_EN_SET = 8'h02;
   localparam logic [7:0] CMD_ARM    = 8'h06;

   localparam int POS_SEL_HI = 7;
   localparam int POS_V2     = 6;
   localparam int POS_V3     = 5;
   localparam int POS_LK_HI  = 4;
   localparam int POS_LK_LO  = 3;
   localparam int POS_ARM    = 2;
   localparam int POS_EN     = 1;
   localparam int POS_SEL_LO = 0;
endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial assert (STAGES >= 0 && STAGES <= 4) else $error("guard_sync: STAGES out of range");

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/guard_lock_dec.sv
module guard_lock_dec
   import guard_csr_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [1:0]        lock,
   input  logic [ADDR_W-1:0] addr,
   output logic              addr_locked,
   output logic              wiper_locked
);
   localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
   localparam logic [ADDR_W-1:0] HALF_BASE = {2'b10, {(ADDR_W-2){1'b0}}};

   initial assert (ADDR_W >= 2) else $error("guard_lock_dec: ADDR_W must be at least 2");

   always_comb begin
      unique case (lock_e'(lock))
         LK_NONE: addr_locked = 1'b0;
         LK_QTR:  addr_locked = (addr >= QTR_BASE);
         LK_HALF: addr_locked = (addr >= HALF_BASE);
         LK_ALL:  addr_locked = 1'b1;
         default: addr_locked = 1'b1;
      endcase
   end

   assign wiper_locked = (lock != LK_NONE);
endmodule

// File: rtl/guard_ctl_core.sv
module guard_ctl_core
   import guard_csr_pkg::*;
#(
   parameter logic [1:0] FACTORY_LOCK = 2'b00,
   parameter logic [1:0] FACTORY_SEL  = 2'b00
) (
   input  logic       clk,
   input  logic       fab_init_n,
   input  logic       pwr_rst_n,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       arm_kill,
   output logic       en_q,
   output logic       arm_q,
   output logic [1:0] lock_q,
   output logic [1:0] sel_q,
   output logic       prog_q,
   output logic       reject
);
   logic do_load, do_set, do_clr, do_arm;

   always_comb begin
      do_load = wr && arm_q;
      do_set  = wr && !arm_q && (wdata == CMD_EN_SET);
      do_clr  = wr && !arm_q && (wdata == CMD_EN_CLR);
      do_arm  = wr && !arm_q && (wdata == CMD_ARM) && en_q;
      reject  = wr && !(do_load || do_set || do_clr || do_arm);
   end

   // volatile latches: lost on power cycle
   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         en_q   <= 1'b0;
         arm_q  <= 1'b0;
         prog_q <= 1'b0;
      end else begin
         if (do_clr)      en_q <= 1'b0;
         else if (do_set) en_q <= 1'b1;
         if (arm_kill || do_load) arm_q <= 1'b0;
         else if (do_arm)         arm_q <= 1'b1;
         prog_q <= do_load;
      end
   end

   // persistent fields: survive power cycle
   always_ff @(posedge clk or negedge fab_init_n) begin
      if (!fab_init_n) begin
         lock_q <= FACTORY_LOCK;
         sel_q  <= FACTORY_SEL;
      end else if (do_load) begin
         lock_q <= wdata[POS_LK_HI:POS_LK_LO];
         sel_q  <= {wdata[POS_SEL_HI], wdata[POS_SEL_LO]};
      end
   end
endmodule

// File: rtl/guard_csr.sv
module guard_csr
   import guard_csr_pkg::*;
#(
   parameter int         ADDR_W       = 8,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [1:0] FACTORY_LOCK = 2'b00,
   parameter logic [1:0] FACTORY_SEL  = 2'b00
) (
   input  logic              clk,
   input  logic              fab_init_n,
   input  logic              pwr_rst_n,
   input  logic              csr_wr,
   input  logic [7:0]        csr_wdata,
   output logic [7:0]        csr_rdata,
   input  logic              mon_v2,
   input  logic              mon_v3,
   input  logic              wp_pin,
   input  logic              req_valid,
   input  logic              req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_permit,
   output logic              abort_pulse,
   output logic              prog_start
);
   logic [1:0] mon_s;
   logic       addr_locked, wiper_locked, blocked, arm_kill, reg_reject;
   logic       en_q, arm_q;
   logic [1:0] lock_q, sel_q;

   guard_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(pwr_rst_n), .d({mon_v2, mon_v3}), .q(mon_s)
   );

   guard_lock_dec #(.ADDR_W(ADDR_W)) u_dec (
      .lock(lock_q), .addr(req_addr),
      .addr_locked(addr_locked), .wiper_locked(wiper_locked)
   );

   guard_ctl_core #(.FACTORY_LOCK(FACTORY_LOCK), .FACTORY_SEL(FACTORY_SEL)) u_core (
      .clk(clk), .fab_init_n(fab_init_n), .pwr_rst_n(pwr_rst_n),
      .wr(csr_wr), .wdata(csr_wdata), .arm_kill(arm_kill),
      .en_q(en_q), .arm_q(arm_q), .lock_q(lock_q), .sel_q(sel_q),
      .prog_q(prog_start), .reject(reg_reject)
   );

   assign blocked    = wp_pin || (req_kind ? wiper_locked : addr_locked);
   assign req_permit = req_valid && !blocked;
   assign arm_kill   = req_valid && !req_kind && addr_locked;

   always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) abort_pulse <= 1'b0;
      else            abort_pulse <= reg_reject || (req_valid && blocked);
   end

   always_comb begin
      csr_rdata             = '0;
      csr_rdata[POS_SEL_HI] = sel_q[1];
      csr_rdata[POS_V2]     = mon_s[1];
      csr_rdata[POS_V3]     = mon_s[0];
      csr_rdata[POS_LK_HI]  = lock_q[1];
      csr_rdata[POS_LK_LO]  = lock_q[0];
      csr_rdata[POS_ARM]    = arm_q;
      csr_rdata[POS_EN]     = en_q;
      csr_rdata[POS_SEL_LO] = sel_q[0];
   end
endmodule

// File: rtl/guard_csr_chk.sv
module guard_csr_chk (
   input logic       clk,
   input logic       fab_init_n,
   input logic       pwr_rst_n,
   input logic [7:0] csr_rdata,
   input logic       wp_pin,
   input logic       req_valid,
   input logic       req_kind,
   input logic       req_permit,
   input logic       abort_pulse,
   input logic       prog_start
);
   // R4: arm latch is never set without the enable latch
   a_r4_arm_needs_en: assert property (@(posedge clk) disable iff (!fab_init_n || !pwr_rst_n)
      csr_rdata[2] |-> csr_rdata[1]);

   // R9: write-protect refuses every request
   a_r9_wp_blocks: assert property (@(posedge clk) disable iff (!fab_init_n || !pwr_rst_n)
      wp_pin |-> !req_permit);

   // R8: a nonzero lock code freezes wipers
   a_r8_wiper_frozen: assert property (@(posedge clk) disable iff (!fab_init_n || !pwr_rst_n)
      (req_valid && req_kind && (csr_rdata[4:3] != 2'b00)) |-> !req_permit);

   // R11: refused request is followed by an abort pulse
   a_r11_abort_follows: assert property (@(posedge clk) disable iff (!fab_init_n || !pwr_rst_n)
      (req_valid && !req_permit) |=> abort_pulse);

   // R6: persistent fields only move after the arm latch was set
   a_r6_fields_hold: assert property (@(posedge clk) disable iff (!fab_init_n || !pwr_rst_n)
      !csr_rdata[2] |=> $stable({csr_rdata[7], csr_rdata[4:3], csr_rdata[0]}));

   // R5: a program pulse needs the arm latch one cycle earlier
   a_r5_prog_after_arm: assert property (@(posedge clk) disable iff (!fab_init_n || !pwr_rst_n)
      prog_start |-> $past(csr_rdata[2]));
endmodule

bind guard_csr guard_csr_chk u_chk (
   .clk(clk), .fab_init_n(fab_init_n), .pwr_rst_n(pwr_rst_n),
   .csr_rdata(csr_rdata), .wp_pin(wp_pin), .req_valid(req_valid),
   .req_kind(req_kind), .req_permit(req_permit),
   .abort_pulse(abort_pulse), .prog_start(prog_start)
);

// File: tb/sim_guard_csr.sv
`timescale 1ns/1ps
module sim_guard_csr;
   localparam int ADDR_W = 8;

   logic clk = 1'b0;
   logic fab_init_n, pwr_rst_n, csr_wr, mon_v2, mon_v3, wp_pin;
   logic req_valid, req_kind, req_permit, abort_pulse, prog_start;
   logic [7:0] csr_wdata, csr_rdata;
   logic [ADDR_W-1:0] req_addr;

   int checks = 0, errors = 0;
   bit done = 0;

   // model state
   bit m_en, m_arm, m_v2, m_v3;
   bit [1:0] m_lock, m_sel;

   always #2.5 clk = ~clk;

   guard_csr u0 (
      .clk(clk), .fab_init_n(fab_init_n), .pwr_rst_n(pwr_rst_n),
      .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .mon_v2(mon_v2), .mon_v3(mon_v3), .wp_pin(wp_pin),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_permit(req_permit), .abort_pulse(abort_pulse), .prog_start(prog_start)
   );

   function automatic bit [7:0] exp_rd();
      return {m_sel[1], m_v2, m_v3, m_lock, m_arm, m_en, m_sel[0]};
   endfunction

   function automatic bit exp_addr_locked(bit [1:0] lk, bit [7:0] a);
      case (lk)
         2'b00: return 1'b0;
         2'b01: return a >= 8'hC0;
         2'b10: return a >= 8'h80;
         default: return 1'b1;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // entered and left on a falling edge
   task automatic reg_op(bit [7:0] d, string tag);
      bit e_abort, e_prog;
      csr_wr = 1'b1; csr_wdata = d;
      e_abort = 0; e_prog = 0;
      if (m_arm) begin
         m_lock = d[4:3]; m_sel = {d[7], d[0]}; m_arm = 0; e_prog = 1;
      end else if (d == 8'h00) m_en = 0;
      else if (d == 8'h02) m_en = 1;
      else if (d == 8'h06 && m_en) m_arm = 1;
      else e_abort = 1;
      @(posedge clk); @(negedge clk);
      csr_wr = 1'b0;
      chk({tag, " rdata"}, csr_rdata, exp_rd());
      chk({tag, " abort"}, abort_pulse, e_abort);
      chk({tag, " prog"}, prog_start, e_prog);
   endtask

   task automatic req_op(bit kind, bit [7:0] a, bit wp, string tag);
      bit lk, e_permit;
      req_valid = 1'b1; req_kind = kind; req_addr = a; wp_pin = wp;
      lk = kind ? (m_lock != 2'b00) : exp_addr_locked(m_lock, a);
      e_permit = !wp && !lk;
      #1;
      chk({tag, " permit"}, req_permit, e_permit);
      if (!kind && exp_addr_locked(m_lock, a)) m_arm = 0;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; wp_pin = 1'b0;
      chk({tag, " abort"}, abort_pulse, !e_permit);
      chk({tag, " rdata"}, csr_rdata, exp_rd());
   endtask

   task automatic program_fields(bit [7:0] d);
      reg_op(8'h02, "R3 en set");
      reg_op(8'h06, "R4 arm");
      reg_op(d, "R5 load");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit [31:0] r;
      void'($urandom(32'h5eed_1234));
      fab_init_n = 0; pwr_rst_n = 0; csr_wr = 0; csr_wdata = 0;
      mon_v2 = 0; mon_v3 = 0; wp_pin = 0; req_valid = 0; req_kind = 0; req_addr = 0;
      m_en = 0; m_arm = 0; m_lock = 0; m_sel = 0; m_v2 = 0; m_v3 = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); fab_init_n = 1; pwr_rst_n = 1;
      @(negedge clk);
      chk("R1 reset rdata", csr_rdata, 8'h00);
      chk("R1 reset abort", abort_pulse, 1'b0);

      // R3/R6: rejected writes with enable low
      reg_op(8'h06, "R4 arm without en");
      reg_op(8'h5A, "R6 bad write");
      reg_op(8'h02, "R3 set");
      reg_op(8'hFF, "R6 bad write en");
      reg_op(8'h00, "R3 clear");
      // R5: load 0x99 -> lock 11, sel 11
      program_fields(8'h99);
      chk("R5 en kept", csr_rdata[1], 1'b1);
      chk("R5 lock field", csr_rdata[4:3], 2'b11);

      // R1: power cycle keeps persistent fields
      pwr_rst_n = 0; @(negedge clk); pwr_rst_n = 1;
      m_en = 0; m_arm = 0;
      chk("R1 power cycle keep", csr_rdata, 8'h99);

      // R7/R8/R9: each lock code at the boundaries
      for (int c = 0; c < 4; c++) begin
         program_fields({3'b000, c[1:0], 3'b000});
         m_en = 1;
         req_op(0, 8'h00, 0, "R7 addr 00");
         req_op(0, 8'h7F, 0, "R7 addr 7F");
         req_op(0, 8'h80, 0, "R7 addr 80");
         req_op(0, 8'hBF, 0, "R7 addr BF");
         req_op(0, 8'hC0, 0, "R7 addr C0");
         req_op(0, 8'hFF, 0, "R7 addr FF");
         req_op(1, 8'h00, 0, "R8 wiper");
         req_op(0, 8'h00, 1, "R9 wp mem");
         req_op(1, 8'h00, 1, "R9 wp wiper");
      end

      // R10: arm then touch a locked address (lock is 11 now)
      reg_op(8'h06, "R10 arm");
      req_op(0, 8'h10, 1, "R10 locked kill");
      chk("R10 arm cleared", csr_rdata[2], 1'b0);
      reg_op(8'h18, "R10 no load after kill");

      // R12: monitor sync delay
      mon_v2 = 1; mon_v3 = 0;
      @(posedge clk); #1;
      chk("R12 one edge", csr_rdata[6], 1'b0);
      @(posedge clk); #1;
      chk("R12 two edges", csr_rdata[6:5], 2'b10);
      m_v2 = 1;
      @(negedge clk);
      mon_v2 = 0; mon_v3 = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      m_v2 = 0; m_v3 = 1;
      chk("R12 v3 flag", csr_rdata[6:5], 2'b01);
      chk("R2 layout", csr_rdata, exp_rd());

      // random phase
      for (int i = 0; i < 600; i++) begin
         r = $urandom;
         case (r[2:0])
            0: reg_op(8'h02, "R3 rnd");
            1: reg_op(8'h00, "R3 rnd");
            2: reg_op(8'h06, "R4 rnd");
            3: reg_op(r[15:8], "R5 R6 rnd");
            default: req_op(r[16], r[31:24], r[17] & r[18], "R7 R8 R9 rnd");
         endcase
      end

      // R1: factory initialise
      fab_init_n = 0; @(negedge clk); fab_init_n = 1;
      m_lock = 0; m_sel = 0;
      chk("R1 factory lock", csr_rdata[4:3], 2'b00);
      chk("R1 factory sel", {csr_rdata[7], csr_rdata[0]}, 2'b00);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule